// File: doc/BRIEF.md
# Device INTx to PIRQ Mapper

This block keeps a small byte-addressed configuration window that decides how the four legacy interrupt pins (INTA to INTD) of devices in slots 25 to 31 reach eight shared PIRQ lines, numbered 0 (A) to 7 (H). Software reprograms the routing through a little-endian read/write port of one to four bytes per access. A combinational lookup port answers "which PIRQ does pin P of slot S drive?" for any of the 32 slots. Each write raises a single-cycle notification, so that downstream interrupt logic can refresh any routing it has cached.

Six of the seven slots in the range own a programmable 16-bit routing word. Slot 30 is hard-wired: its word reads as zero and its pins always land on PIRQ E to H. A slot outside 25 to 31 follows a fixed arithmetic table that spreads its pins over PIRQ E to H. After reset every programmable word holds 0x3210, which sends pins A to D to PIRQ A to D.

Top module: `intx_pirq_mapper`

## Requirements
- R1: While `rst_n` is low at a clock edge, every window byte is cleared and then the programmable routing words are loaded with 0x3210. After reset, `route_chg` is 0, `acc_rdata` is 0, and slots 25 to 29 and 31 map pin n to PIRQ n.
- R2: For a slot below 25, `lk_pirq` is ((slot + pin) mod 4) + 4. No write to the window changes this.
- R3: The routing word of slot s (s = 25 to 31) is at byte offset 0x20 + 2·(s − 25), low byte first. Pin n takes bits [4n+2:4n] of the word as its PIRQ index, and bit 4n+3 is stored but ignored.
- R4: Slot 30's word (bytes 0x2A and 0x2B) always reads as zero and ignores writes. The lookup for slot 30 pin n is always n + 4.
- R5: Only the low 6 bits of `acc_addr` select the byte offset in the 64-byte window. Higher address bits have no effect.
- R6: An access covers `acc_size`+1 bytes. If offset + length ≥ 64, the length is clipped to 64 − offset, and the access never wraps to offset 0.
- R7: Byte offset+k travels in lane k (`acc_rdata`/`acc_wdata` bits 8k+7:8k). A read returns zero in the lanes past the clipped length. Read data appears in the cycle after the request and holds until the next read.
- R8: `route_chg` is high for exactly the cycle after each accepted write, whether or not the write was clipped or landed on read-only bytes. A read leaves `route_chg` low.
- R9: The lookup is combinational. It shows the result of a write from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Window access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Byte address, masked to the window |
| acc_size | input | 2 | Byte count minus one (0 to 3) |
| acc_wdata | input | 32 | Little-endian write data |
| acc_rdata | output | 32 | Little-endian read data, registered |
| lk_slot | input | 5 | Device slot to look up |
| lk_pin | input | 2 | INTx pin, 0 = A to 3 = D |
| lk_pirq | output | 3 | PIRQ index, 0 = A to 7 = H |
| route_chg | output | 1 | One-cycle pulse after a write |

## Verification
A write driven before one rising edge updates the window at that edge. `route_chg` and the lookup result for the new routing are both valid after that edge, and `route_chg` falls at the following edge. A read's data is also due one edge after the request. The bench drives each access on a falling edge and samples its results on the next falling edge, which is exactly one rising edge later. Lookups are sampled with short delays while no write is pending, so the value seen depends only on the stored window.

// File: rtl/intx_map_pkg.sv
// Shared helpers for the INTx to PIRQ mapper.
// Assumes 32 device slots and four INTx pins per slot.
package intx_map_pkg;
    localparam int SLOT_W = 5;
    localparam int PIN_W  = 2;
    localparam int PIRQ_W = 3;

    // Fixed spread for slots without a routing word: ((slot + pin) mod 4) + 4.
    function automatic logic [PIRQ_W-1:0] arith_pirq(input logic [SLOT_W-1:0] slot,
                                                     input logic [PIN_W-1:0] pin);
        logic [1:0] sum;
        sum = slot[1:0] + pin;
        return {1'b1, sum};
    endfunction
endpackage

// File: rtl/cc_window.sv
// Byte-addressed configuration window holding the routing words.
// Assumes WIN_BYTES is a power of two of at least 8 and accesses of 1..4 bytes.
// It masks the address to the window, clips the length at the window end,
// keeps the read-only word at zero and loads the routing defaults on reset.
module cc_window #(
    parameter int          WIN_BYTES    = 64,
    parameter int          ADDR_W       = 16,
    parameter int          RT_BASE      = 32,
    parameter int          NUM_RT       = 7,
    parameter int          RO_IDX       = 5,
    parameter logic [15:0] DEFAULT_WORD = 16'h3210
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [1:0]             acc_size,
    input  logic [31:0]            acc_wdata,
    output logic [31:0]            acc_rdata,
    output logic [NUM_RT-1:0][15:0] rt_words
);
    localparam int OFF_W = $clog2(WIN_BYTES);
    localparam logic [OFF_W:0] WIN_L = (OFF_W+1)'(WIN_BYTES);

    // True for the two bytes of the read-only routing word.
    function automatic bit byte_is_ro(input int b);
        return (b >= RT_BASE + 2*RO_IDX) && (b < RT_BASE + 2*RO_IDX + 2);
    endfunction

    // Reset value of a byte: routing-word halves get the default, others zero.
    function automatic logic [7:0] byte_rst(input int b);
        if (b >= RT_BASE && b < RT_BASE + 2*NUM_RT && !byte_is_ro(b))
            return ((b - RT_BASE) % 2 == 0) ? DEFAULT_WORD[7:0] : DEFAULT_WORD[15:8];
        return 8'h00;
    endfunction

    logic [OFF_W-1:0] off;
    logic [OFF_W:0]   req_len;
    logic [OFF_W:0]   end_sum;
    logic [OFF_W:0]   eff_len;
    logic             wr_fire;
    logic [7:0]       byte_vec [WIN_BYTES];
    logic [31:0]      rd_next;
    logic             unused_addr_hi;

    assign off            = acc_addr[OFF_W-1:0];
    assign unused_addr_hi = ^acc_addr[ADDR_W-1:OFF_W];
    assign wr_fire        = acc_valid && acc_write;

    // Effective access length after clipping at the window end.
    always_comb begin
        req_len = (OFF_W+1)'(acc_size) + (OFF_W+1)'(1);
        end_sum = {1'b0, off} + req_len;
        if (end_sum >= WIN_L)
            eff_len = WIN_L - {1'b0, off};
        else
            eff_len = req_len;
    end

    for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
        if (byte_is_ro(b)) begin : g_ro
            assign byte_vec[b] = 8'h00;
        end else begin : g_rw
            localparam logic [OFF_W-1:0] B_IDX = OFF_W'(b);
            logic [OFF_W-1:0] rel;
            logic             hit;
            logic [7:0]       q;
            assign rel = B_IDX - off;
            assign hit = ({1'b0, rel} < eff_len);
            // Store the lane that lands on this byte, or load the reset value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= byte_rst(b);
                else if (wr_fire && hit)
                    q <= acc_wdata[{rel[1:0], 3'b000} +: 8];
            end
            assign byte_vec[b] = q;
        end
    end

    // Gather the read lanes, zero past the clipped length.
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            if ((OFF_W+1)'(k) < eff_len)
                rd_next[8*k +: 8] = byte_vec[off + OFF_W'(k)];
            else
                rd_next[8*k +: 8] = 8'h00;
        end
    end

    // Register read data on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_rdata <= '0;
        else if (acc_valid && !acc_write)
            acc_rdata <= rd_next;
    end

    for (genvar r = 0; r < NUM_RT; r++) begin : g_word
        assign rt_words[r] = {byte_vec[RT_BASE + 2*r + 1], byte_vec[RT_BASE + 2*r]};
    end
endmodule

// File: rtl/route_lookup.sv
// Combinational (slot, pin) to PIRQ lookup.
// Assumes the routing words arrive already assembled, one per slot from
// FIRST_SLOT, and that RO_IDX names the hard-wired slot.
module route_lookup
    import intx_map_pkg::*;
#(
    parameter int FIRST_SLOT  = 25,
    parameter int NUM_RT      = 7,
    parameter int RO_IDX      = 5,
    parameter int FIELD_SHIFT = 4
) (
    input  logic [NUM_RT-1:0][15:0] rt_words,
    input  logic [SLOT_W-1:0]       lk_slot,
    input  logic [PIN_W-1:0]        lk_pin,
    output logic [PIRQ_W-1:0]       lk_pirq
);
    localparam int IDX_W = $clog2(NUM_RT);
    localparam logic [SLOT_W-1:0] LO = SLOT_W'(FIRST_SLOT);
    localparam logic [SLOT_W-1:0] HI = SLOT_W'(FIRST_SLOT + NUM_RT - 1);

    logic [PIRQ_W-1:0] dec [NUM_RT][4];
    logic [SLOT_W-1:0] rel_slot;
    logic [IDX_W-1:0]  rel_idx;
    logic              unused_words;

    assign unused_words = ^rt_words;

    for (genvar r = 0; r < NUM_RT; r++) begin : g_slot
        for (genvar p = 0; p < 4; p++) begin : g_pin
            if (r == RO_IDX) begin : g_fixed
                assign dec[r][p] = PIRQ_W'(p + 4);
            end else begin : g_field
                assign dec[r][p] = rt_words[r][p*FIELD_SHIFT +: PIRQ_W];
            end
        end
    end

    assign rel_slot = lk_slot - LO;
    assign rel_idx  = rel_slot[IDX_W-1:0];

    // Pick the decoded field for a programmable slot, else the fixed spread.
    always_comb begin
        if (lk_slot >= LO && lk_slot <= HI)
            lk_pirq = dec[rel_idx][lk_pin];
        else
            lk_pirq = arith_pirq(lk_slot, lk_pin);
    end
endmodule

// File: rtl/route_notify.sv
// One-cycle routing-changed pulse, registered from a write strobe.
// Assumes a write strobe of one cycle per accepted write.
module route_notify (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire,
    output logic route_chg
);
    // Follow the write strobe one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_chg <= 1'b0;
        else
            route_chg <= wr_fire;
    end
endmodule

// File: rtl/intx_pirq_mapper.sv
// Top of the INTx to PIRQ mapper: configuration window, lookup and change pulse.
// Assumes one access per cycle and a lookup port driven independently.
module intx_pirq_mapper
    import intx_map_pkg::*;
#(
    parameter int          WIN_BYTES    = 64,
    parameter int          ADDR_W       = 16,
    parameter int          RT_BASE      = 32,
    parameter int          FIRST_SLOT   = 25,
    parameter int          NUM_RT       = 7,
    parameter int          RO_SLOT      = 30,
    parameter int          FIELD_SHIFT  = 4,
    parameter logic [15:0] DEFAULT_WORD = 16'h3210
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [1:0]          acc_size,
    input  logic [31:0]         acc_wdata,
    output logic [31:0]         acc_rdata,
    input  logic [SLOT_W-1:0]   lk_slot,
    input  logic [PIN_W-1:0]    lk_pin,
    output logic [PIRQ_W-1:0]   lk_pirq,
    output logic                route_chg
);
    localparam int RO_IDX = RO_SLOT - FIRST_SLOT;

    logic [NUM_RT-1:0][15:0] rt_words;

    cc_window #(
        .WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W), .RT_BASE(RT_BASE),
        .NUM_RT(NUM_RT), .RO_IDX(RO_IDX), .DEFAULT_WORD(DEFAULT_WORD)
    ) u_win (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .rt_words(rt_words)
    );

    route_lookup #(
        .FIRST_SLOT(FIRST_SLOT), .NUM_RT(NUM_RT), .RO_IDX(RO_IDX),
        .FIELD_SHIFT(FIELD_SHIFT)
    ) u_lk (
        .rt_words(rt_words), .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
    );

    route_notify u_chg (
        .clk(clk), .rst_n(rst_n), .wr_fire(acc_valid && acc_write),
        .route_chg(route_chg)
    );
endmodule

// File: rtl/intx_pirq_mapper_chk.sv
// Port-level checker for the INTx to PIRQ mapper, attached by bind.
// Assumes the default slot numbering (first slot 25, hard-wired slot 30).
module intx_pirq_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [1:0]  acc_size,
    input logic [31:0] acc_rdata,
    input logic [4:0]  lk_slot,
    input logic [1:0]  lk_pin,
    input logic [2:0]  lk_pirq,
    input logic        route_chg
);
    // R8
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> route_chg);

    // R8
    no_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write) |=> !route_chg);

    // R4
    ro_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_slot == 5'd30) |-> (lk_pirq == {1'b1, lk_pin}));

    // R2
    spread_tbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_slot < 5'd25) |-> (lk_pirq == {1'b1, lk_slot[1:0] + lk_pin}));

    // R7
    lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_size == 2'd0) |=> (acc_rdata[31:8] == 24'h0));
endmodule

bind intx_pirq_mapper intx_pirq_mapper_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_rdata(acc_rdata), .lk_slot(lk_slot),
    .lk_pin(lk_pin), .lk_pirq(lk_pirq), .route_chg(route_chg)
);

// File: tb/tb_intx_pirq_mapper.sv
`timescale 1ns/1ps
module tb_intx_pirq_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [4:0]  lk_slot = '0;
    logic [1:0]  lk_pin = '0;
    logic [2:0]  lk_pirq;
    logic        route_chg;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [7:0] mdl [64];

    intx_pirq_mapper dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .lk_slot(lk_slot), .lk_pin(lk_pin),
        .lk_pirq(lk_pirq), .route_chg(route_chg)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit is_ro(input int b);
        return b == 8'h2A || b == 8'h2B;
    endfunction

    task automatic mdl_reset();
        for (int b = 0; b < 64; b++) mdl[b] = 8'h00;
        for (int s = 0; s < 7; s++) begin
            if (s != 5) begin
                mdl[32 + 2*s]     = 8'h10;
                mdl[32 + 2*s + 1] = 8'h32;
            end
        end
    endtask

    function automatic int clip_len(input int addr, input int size);
        int off, n;
        off = addr % 64;
        n = size + 1;
        if (off + n >= 64) n = 64 - off;
        return n;
    endfunction

    function automatic logic [31:0] exp_read(input int addr, input int size);
        logic [31:0] v;
        int off, n;
        v = '0;
        off = addr % 64;
        n = clip_len(addr, size);
        for (int k = 0; k < n; k++) v[8*k +: 8] = mdl[off + k];
        return v;
    endfunction

    function automatic logic [2:0] exp_pirq(input int s, input int p);
        logic [15:0] w;
        if (s == 30) return 3'(p + 4);
        if (s >= 25) begin
            w = {mdl[32 + 2*(s-25) + 1], mdl[32 + 2*(s-25)]};
            return 3'((w >> (4*p)) & 16'h7);
        end
        return 3'(((s + p) % 4) + 4);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mdl_reset();
    endtask

    task automatic do_write(input int addr, input int size, input logic [31:0] data);
        int off, n;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1;
        acc_addr = 16'(addr); acc_size = 2'(size); acc_wdata = data;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        off = addr % 64;
        n = clip_len(addr, size);
        for (int k = 0; k < n; k++)
            if (!is_ro(off + k)) mdl[off + k] = data[8*k +: 8];
        check("R8 pulse after write", 32'(route_chg), 32'd1);
    endtask

    task automatic do_read(input int addr, input int size);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0;
        acc_addr = 16'(addr); acc_size = 2'(size);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R7 read data", acc_rdata, exp_read(addr, size));
        check("R8 no pulse on read", 32'(route_chg), 32'd0);
    endtask

    task automatic sweep();
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                lk_slot = 5'(s); lk_pin = 2'(p);
                #0.1;
                if (s == 30)      check("R4 fixed slot lookup", 32'(lk_pirq), 32'(exp_pirq(s, p)));
                else if (s >= 25) check("R3 routed lookup", 32'(lk_pirq), 32'(exp_pirq(s, p)));
                else              check("R2 spread lookup", 32'(lk_pirq), 32'(exp_pirq(s, p)));
            end
        end
    endtask

    initial begin
        int addr, size;
        logic [31:0] data;
        void'($urandom(32'h5EED1234));
        mdl_reset();
        do_reset();
        // R1: reset state
        @(negedge clk);
        check("R1 route_chg after reset", 32'(route_chg), 32'd0);
        check("R1 rdata after reset", acc_rdata, 32'd0);
        lk_slot = 5'd28; lk_pin = 2'd3; #0.1;
        check("R1 default routing", 32'(lk_pirq), 32'd3);
        do_read(32'h20, 1);
        check("R1 default word", acc_rdata, 32'h3210);
        do_read(32'h2A, 1);
        sweep();

        // R3: field bit 3 ignored
        do_write(32'h20, 0, 32'hFE);
        lk_slot = 5'd25; lk_pin = 2'd0; #0.1;
        check("R3 field low bits", 32'(lk_pirq), 32'd6);
        lk_pin = 2'd1; #0.1;
        check("R3 second field", 32'(lk_pirq), 32'd7);

        // R4: read-only word ignores writes
        do_write(32'h2A, 1, 32'hFFFF);
        do_read(32'h2A, 1);
        check("R4 ro word reads zero", acc_rdata, 32'd0);

        // R6: clip at window end, no wrap
        do_write(32'h3E, 2, 32'hAABBCC);
        do_read(32'h00, 0);
        check("R6 no wrap to byte 0", acc_rdata, 32'd0);
        do_read(32'h3E, 3);
        check("R6 clipped read", acc_rdata, 32'h0000BBCC);

        // R5: high address bits masked
        do_write(32'h1024, 1, 32'h4567);
        lk_slot = 5'd27; lk_pin = 2'd2; #0.1;
        check("R5 masked address", 32'(lk_pirq), 32'd5);

        // R7: single-byte read lanes
        do_read(32'h21, 0);

        // R9: lookup reflects write at the next cycle
        lk_slot = 5'd29; lk_pin = 2'd0;
        do_write(32'h28, 0, 32'h07);
        check("R9 lookup after write", 32'(lk_pirq), 32'd7);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            addr = ($urandom % 2) ? 32'(32 + $urandom % 16) : 32'($urandom % 65536);
            size = int'($urandom % 4);
            data = $urandom;
            if ($urandom % 2) do_write(addr, size, data);
            else              do_read(addr, size);
            if (i % 40 == 39) sweep();
        end
        sweep();

        // R1: reset restores defaults
        do_reset();
        @(negedge clk);
        do_read(32'h22, 3);
        check("R1 defaults restored", acc_rdata, 32'h32103210);
        sweep();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule